// File: doc/BRIEF.md
# Shared RAM Access Protection Unit

This block sits beside the memory of a two-subsystem chip and judges every access a CPU makes to one of its RAM blocks. Each block belongs to one of three kinds. An exempt block is never checked. A dedicated block belongs to one subsystem. A shared block has a master subsystem that software selects at run time. Reads are never refused to a CPU that can reach a block. Fetches and writes are refused when the CPU is not the block's master, or when the block's own fetch-protect or write-protect bit is set.

A refused fetch or write never reaches the memory. It raises a one-cycle fault pulse toward the offending CPU: subsystem A receives a bus fault and subsystem B receives an illegal-instruction trap. It also sets a sticky flag in that subsystem's flag register. Each subsystem has its own fetch-address and write-address capture registers, and each of these keeps the first faulting address until software clears the matching flags by writing ones to the clear inputs.

The block index is taken from the top bits of the address. With the default parameters there are eight blocks selected by `req_addr[15:13]`. Blocks 0 and 1 are exempt. Block 2 is dedicated to A, block 3 is dedicated to B, and blocks 4 to 7 are shared.

Top module: `rap_top`

## Requirements
- R1: A read (`req_kind` 2'b00, with 2'b11 also treated as a read) to any block the CPU can reach is granted whatever the protect bits and the mastership, and it never raises a fault or a flag.
- R2: A fetch (`req_kind` 2'b10) or a write (2'b01) is granted when the CPU is the block's master and the relevant protect bit is clear. `req_cpu` 0 is subsystem A and 1 is subsystem B. The master of shared block i is given by `blk_master[i]` (0 means A, 1 means B). Block 2 is owned by A and block 3 is owned by B.
- R3: A fetch by the master while `blk_fetch_prot[i]` is 1 is refused and sets flag bit 0, the master-fetch violation.
- R4: A write by the master while `blk_wr_prot[i]` is 1 is refused and sets flag bit 1, the master-write violation.
- R5: A fetch to a shared block by the CPU that is not its master sets flag bit 2. A write to a shared block by the CPU that is not its master sets flag bit 3. Both accesses are refused.
- R6: Accesses of every kind, by either CPU, to exempt blocks 0 and 1 are granted and set no flag, even with all protect bits set.
- R7: A violation raises `bus_fault_a` (CPU A) or `trap_b` (CPU B) for exactly one cycle, in the cycle after the access.
- R8: A violation updates only the flags and the address registers of the offending CPU's subsystem.
- R9: A fetch violation latches the address into the subsystem's fetch-address register only if neither of its fetch flags (bits 0 and 2) is still set. A write violation does the same with the write-address register and write flags (bits 1 and 3). Otherwise the earlier address is kept.
- R10: Flags are sticky. A 1 on `flag_clr_a[k]` or `flag_clr_b[k]` clears flag bit k of that subsystem and leaves the other bits unchanged.
- R11: When a violation and a clear of the same flag happen in one cycle, the flag ends set and the address register takes the new address.
- R12: `mem_wr_en` is high only for a granted write, and `fetch_valid` is high only for a granted fetch. With no valid request, nothing is granted.
- R13: An access to a block dedicated to the other subsystem is refused and raises no fault and no flag.
- R14: After reset, all flags and address registers are zero, and both fault outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_cpu | input | 1 | Requesting CPU, 0 = A, 1 = B |
| req_kind | input | 2 | 00 read, 01 write, 10 fetch, 11 read |
| req_addr | input | 16 | Access address |
| blk_master | input | 8 | Master subsystem of each shared block |
| blk_fetch_prot | input | 8 | Per-block fetch-protect bits |
| blk_wr_prot | input | 8 | Per-block write-protect bits |
| flag_clr_a | input | 4 | Write-one-to-clear pulses for A flags |
| flag_clr_b | input | 4 | Write-one-to-clear pulses for B flags |
| req_grant | output | 1 | Access allowed |
| mem_wr_en | output | 1 | Write enable passed to the RAM |
| fetch_valid | output | 1 | Fetch data may be used |
| bus_fault_a | output | 1 | Fault pulse to CPU A |
| trap_b | output | 1 | Trap pulse to CPU B |
| viol_flags_a | output | 4 | Subsystem A violation flags |
| viol_flags_b | output | 4 | Subsystem B violation flags |
| fetch_vaddr_a | output | 16 | A fetch-violation address |
| write_vaddr_a | output | 16 | A write-violation address |
| fetch_vaddr_b | output | 16 | B fetch-violation address |
| write_vaddr_b | output | 16 | B write-violation address |

## Verification
The bench targets reads that are made with every protect bit set. A design that applied the protect bits to reads would fault here. It sends a second fetch violation while the first flag is still set. A unit that failed to hold the captured address would overwrite the first faulting address. It fires a violation in the same cycle as the clear of that same flag. A design that gave the clear priority would lose the event. It also tries accesses to exempt blocks and to the other subsystem's dedicated block, where a wrong decode would produce a spurious grant, fault or flag. Each violation is checked on the correct subsystem's fault line and registers only.

// File: rtl/rap_pkg.sv
package rap_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'b00,
    ACC_WRITE = 2'b01,
    ACC_FETCH = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  localparam int NUM_FLG      = 4;
  localparam int FLG_M_FETCH  = 0;
  localparam int FLG_M_WRITE  = 1;
  localparam int FLG_NM_FETCH = 2;
  localparam int FLG_NM_WRITE = 3;

  localparam logic [NUM_FLG-1:0] FETCH_FLG_MASK = 4'b0101;
  localparam logic [NUM_FLG-1:0] WRITE_FLG_MASK = 4'b1010;

  typedef struct packed {
    logic exempt;
    logic shared;
    logic owner;
    logic cur_master;
    logic fprot;
    logic wprot;
  } blk_attr_t;
endpackage

// File: rtl/rap_blk_sel.sv
module rap_blk_sel
  import rap_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter logic [NUM_BLK-1:0] EXEMPT_MASK = 8'b0000_0011,
  parameter logic [NUM_BLK-1:0] SHARED_MASK = 8'b1111_0000,
  parameter logic [NUM_BLK-1:0] OWNER_MASK  = 8'b0000_1000,
  localparam int BIDX_W = $clog2(NUM_BLK)
) (
  input  logic [BIDX_W-1:0]  blk_idx,
  input  logic [NUM_BLK-1:0] blk_master,
  input  logic [NUM_BLK-1:0] blk_fetch_prot,
  input  logic [NUM_BLK-1:0] blk_wr_prot,
  output blk_attr_t          attr
);
  blk_attr_t attr_tab [NUM_BLK];

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    always_comb begin
      attr_tab[b].exempt     = EXEMPT_MASK[b];
      attr_tab[b].shared     = SHARED_MASK[b] & ~EXEMPT_MASK[b];
      attr_tab[b].owner      = OWNER_MASK[b];
      attr_tab[b].cur_master = blk_master[b];
      attr_tab[b].fprot      = blk_fetch_prot[b];
      attr_tab[b].wprot      = blk_wr_prot[b];
    end
  end

  assign attr = attr_tab[blk_idx];
endmodule

// File: rtl/rap_classify.sv
module rap_classify
  import rap_pkg::*;
(
  input  logic               req_valid,
  input  logic               req_cpu,
  input  logic [1:0]         req_kind,
  input  blk_attr_t          attr,
  output logic               grant,
  output logic [NUM_FLG-1:0] viol
);
  logic is_fetch;
  logic is_write;
  logic reach;
  logic master;
  logic prot;

  always_comb begin
    is_fetch = (req_kind == ACC_FETCH);
    is_write = (req_kind == ACC_WRITE);
    reach    = attr.exempt | attr.shared | (attr.owner == req_cpu);
    master   = attr.shared ? attr.cur_master : attr.owner;
    prot     = is_fetch ? attr.fprot : attr.wprot;
    grant    = 1'b0;
    viol     = '0;
    if (req_valid && reach) begin
      if (attr.exempt || !(is_fetch || is_write)) begin
        grant = 1'b1;
      end else if (master != req_cpu) begin
        viol[is_fetch ? FLG_NM_FETCH : FLG_NM_WRITE] = 1'b1;
      end else if (prot) begin
        viol[is_fetch ? FLG_M_FETCH : FLG_M_WRITE] = 1'b1;
      end else begin
        grant = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rap_sub_regs.sv
module rap_sub_regs
  import rap_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit,
  input  logic [NUM_FLG-1:0] viol,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_FLG-1:0] clr,
  output logic [NUM_FLG-1:0] flags,
  output logic [ADDR_W-1:0]  fetch_addr,
  output logic [ADDR_W-1:0]  write_addr,
  output logic               fault
);
  logic [NUM_FLG-1:0] flags_q, flags_d, set_v, kept;
  logic [ADDR_W-1:0]  faddr_q, waddr_q;
  logic               fault_q, fault_d;
  logic               faddr_en, waddr_en;

  always_comb begin
    set_v    = hit ? viol : '0;
    kept     = flags_q & ~clr;
    flags_d  = kept | set_v;
    faddr_en = |(set_v & FETCH_FLG_MASK) && !(|(kept & FETCH_FLG_MASK));
    waddr_en = |(set_v & WRITE_FLG_MASK) && !(|(kept & WRITE_FLG_MASK));
    fault_d  = |set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      fault_q <= 1'b0;
    end else begin
      flags_q <= flags_d;
      fault_q <= fault_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      faddr_q <= '0;
    end else if (faddr_en) begin
      faddr_q <= addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr_q <= '0;
    end else if (waddr_en) begin
      waddr_q <= addr;
    end
  end

  assign flags      = flags_q;
  assign fetch_addr = faddr_q;
  assign write_addr = waddr_q;
  assign fault      = fault_q;
endmodule

// File: rtl/rap_top.sv
module rap_top
  import rap_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_BLK = 8,
  parameter logic [NUM_BLK-1:0] EXEMPT_MASK = 8'b0000_0011,
  parameter logic [NUM_BLK-1:0] SHARED_MASK = 8'b1111_0000,
  parameter logic [NUM_BLK-1:0] OWNER_MASK  = 8'b0000_1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_cpu,
  input  logic [1:0]         req_kind,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [NUM_BLK-1:0] blk_master,
  input  logic [NUM_BLK-1:0] blk_fetch_prot,
  input  logic [NUM_BLK-1:0] blk_wr_prot,
  input  logic [3:0]         flag_clr_a,
  input  logic [3:0]         flag_clr_b,
  output logic               req_grant,
  output logic               mem_wr_en,
  output logic               fetch_valid,
  output logic               bus_fault_a,
  output logic               trap_b,
  output logic [3:0]         viol_flags_a,
  output logic [3:0]         viol_flags_b,
  output logic [ADDR_W-1:0]  fetch_vaddr_a,
  output logic [ADDR_W-1:0]  write_vaddr_a,
  output logic [ADDR_W-1:0]  fetch_vaddr_b,
  output logic [ADDR_W-1:0]  write_vaddr_b
);
  localparam int BIDX_W = $clog2(NUM_BLK);
  localparam int NUM_SUB = 2;

  logic               rst_meta_n, rst_sync_n;
  blk_attr_t          attr;
  logic               grant;
  logic [NUM_FLG-1:0] viol;
  logic [NUM_FLG-1:0] clr_v   [NUM_SUB];
  logic [NUM_FLG-1:0] flags_v [NUM_SUB];
  logic [ADDR_W-1:0]  faddr_v [NUM_SUB];
  logic [ADDR_W-1:0]  waddr_v [NUM_SUB];
  logic               fault_v [NUM_SUB];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  rap_blk_sel #(
    .NUM_BLK     (NUM_BLK),
    .EXEMPT_MASK (EXEMPT_MASK),
    .SHARED_MASK (SHARED_MASK),
    .OWNER_MASK  (OWNER_MASK)
  ) u_sel (
    .blk_idx        (req_addr[ADDR_W-1 -: BIDX_W]),
    .blk_master     (blk_master),
    .blk_fetch_prot (blk_fetch_prot),
    .blk_wr_prot    (blk_wr_prot),
    .attr           (attr)
  );

  rap_classify u_cls (
    .req_valid (req_valid),
    .req_cpu   (req_cpu),
    .req_kind  (req_kind),
    .attr      (attr),
    .grant     (grant),
    .viol      (viol)
  );

  assign clr_v[0] = flag_clr_a;
  assign clr_v[1] = flag_clr_b;

  for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
    rap_sub_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .hit        (req_cpu == 1'(s)),
      .viol       (viol),
      .addr       (req_addr),
      .clr        (clr_v[s]),
      .flags      (flags_v[s]),
      .fetch_addr (faddr_v[s]),
      .write_addr (waddr_v[s]),
      .fault      (fault_v[s])
    );
  end

  assign req_grant     = grant;
  assign mem_wr_en     = grant && (req_kind == ACC_WRITE);
  assign fetch_valid   = grant && (req_kind == ACC_FETCH);
  assign bus_fault_a   = fault_v[0];
  assign trap_b        = fault_v[1];
  assign viol_flags_a  = flags_v[0];
  assign viol_flags_b  = flags_v[1];
  assign fetch_vaddr_a = faddr_v[0];
  assign write_vaddr_a = waddr_v[0];
  assign fetch_vaddr_b = faddr_v[1];
  assign write_vaddr_b = waddr_v[1];
endmodule

// File: rtl/rap_chk.sv
module rap_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              req_valid,
  input logic              req_cpu,
  input logic [1:0]        req_kind,
  input logic [3:0]        flag_clr_a,
  input logic [3:0]        flag_clr_b,
  input logic              req_grant,
  input logic              mem_wr_en,
  input logic              fetch_valid,
  input logic              bus_fault_a,
  input logic              trap_b,
  input logic [3:0]        viol_flags_a,
  input logic [3:0]        viol_flags_b,
  input logic [ADDR_W-1:0] fetch_vaddr_a,
  input logic [ADDR_W-1:0] write_vaddr_a
);
  AST_READ_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && (req_kind == 2'b00 || req_kind == 2'b11)) |=> (!bus_fault_a && !trap_b)); // R1

  AST_FAULT_A_SRC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    bus_fault_a |-> $past(req_valid && !req_cpu && !req_grant)); // R7

  AST_TRAP_B_SRC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trap_b |-> $past(req_valid && req_cpu && !req_grant)); // R7

  AST_FLAGS_STICKY_A: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ((viol_flags_a & $past(viol_flags_a & ~flag_clr_a)) == $past(viol_flags_a & ~flag_clr_a))); // R10

  AST_FLAGS_STICKY_B: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ((viol_flags_b & $past(viol_flags_b & ~flag_clr_b)) == $past(viol_flags_b & ~flag_clr_b))); // R10

  AST_FETCH_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|(viol_flags_a & ~flag_clr_a & 4'b0101)) |=> $stable(fetch_vaddr_a)); // R9

  AST_WRITE_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|(viol_flags_a & ~flag_clr_a & 4'b1010)) |=> $stable(write_vaddr_a)); // R9

  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |-> (!req_grant && !mem_wr_en && !fetch_valid)); // R12
endmodule

bind rap_top rap_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_sync_n    (rst_sync_n),
  .req_valid     (req_valid),
  .req_cpu       (req_cpu),
  .req_kind      (req_kind),
  .flag_clr_a    (flag_clr_a),
  .flag_clr_b    (flag_clr_b),
  .req_grant     (req_grant),
  .mem_wr_en     (mem_wr_en),
  .fetch_valid   (fetch_valid),
  .bus_fault_a   (bus_fault_a),
  .trap_b        (trap_b),
  .viol_flags_a  (viol_flags_a),
  .viol_flags_b  (viol_flags_b),
  .fetch_vaddr_a (fetch_vaddr_a),
  .write_vaddr_a (write_vaddr_a)
);

// File: tb/sim_rap_top.sv
`timescale 1ns/1ps
module sim_rap_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_cpu;
  logic [1:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  blk_master, blk_fetch_prot, blk_wr_prot;
  logic [3:0]  flag_clr_a, flag_clr_b;
  logic        req_grant, mem_wr_en, fetch_valid, bus_fault_a, trap_b;
  logic [3:0]  viol_flags_a, viol_flags_b;
  logic [15:0] fetch_vaddr_a, write_vaddr_a, fetch_vaddr_b, write_vaddr_b;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;
  logic s_grant, s_we, s_fv, s_fa, s_tb;

  always #10 clk = ~clk;

  rap_top u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_acc(input logic cpu, input logic [1:0] kind, input logic [15:0] addr,
                        input logic [3:0] ca, input logic [3:0] cb);
    @(negedge clk);
    req_valid = 1'b1; req_cpu = cpu; req_kind = kind; req_addr = addr;
    flag_clr_a = ca; flag_clr_b = cb;
    #2;
    s_grant = req_grant; s_we = mem_wr_en; s_fv = fetch_valid;
    @(negedge clk);
    req_valid = 1'b0; flag_clr_a = '0; flag_clr_b = '0;
    s_fa = bus_fault_a; s_tb = trap_b;
  endtask

  task automatic do_clr(input logic [3:0] ca, input logic [3:0] cb);
    @(negedge clk);
    flag_clr_a = ca; flag_clr_b = cb;
    @(negedge clk);
    flag_clr_a = '0; flag_clr_b = '0;
  endtask

  task automatic t_reset();
    chk("R14 flags_a", viol_flags_a, 0);
    chk("R14 flags_b", viol_flags_b, 0);
    chk("R14 addrs", {fetch_vaddr_a, write_vaddr_a}, 0);
    chk("R14 addrs_b", {fetch_vaddr_b, write_vaddr_b}, 0);
    chk("R14 faults", {bus_fault_a, trap_b}, 0);
    chk("R12 idle grant", {req_grant, mem_wr_en, fetch_valid}, 0);
  endtask

  task automatic t_allowed();
    blk_master = '0; blk_fetch_prot = '0; blk_wr_prot = '0;
    do_acc(0, 2'b10, 16'h8004, 0, 0);
    chk("R2 fetch grant", {s_grant, s_fv, s_we}, 3'b110);
    do_acc(0, 2'b01, 16'h8008, 0, 0);
    chk("R12 write enable", {s_grant, s_we, s_fv}, 3'b110);
    do_acc(1, 2'b10, 16'h6000, 0, 0);
    chk("R2 owner fetch", {s_grant, s_tb}, 2'b10);
    chk("R2 no flags", {viol_flags_a, viol_flags_b}, 0);
  endtask

  task automatic t_reads();
    blk_fetch_prot = 8'hFF; blk_wr_prot = 8'hFF; blk_master[5] = 1'b1;
    do_acc(0, 2'b00, 16'hA000, 0, 0);
    chk("R1 nonmaster read", {s_grant, s_fa}, 2'b10);
    do_acc(0, 2'b11, 16'h8000, 0, 0);
    chk("R1 code11 read", {s_grant, s_fa}, 2'b10);
    chk("R1 no flags", {viol_flags_a, viol_flags_b}, 0);
  endtask

  task automatic t_exempt();
    do_acc(1, 2'b10, 16'h0010, 0, 0);
    chk("R6 exempt fetch", {s_grant, s_fv, s_tb}, 3'b110);
    do_acc(0, 2'b01, 16'h2020, 0, 0);
    chk("R6 exempt write", {s_grant, s_we, s_fa}, 3'b110);
    chk("R6 no flags", {viol_flags_a, viol_flags_b}, 0);
  endtask

  task automatic t_foreign();
    do_acc(0, 2'b01, 16'h6004, 0, 0);
    chk("R13 A to B block", {s_grant, s_we, s_fa}, 0);
    do_acc(1, 2'b10, 16'h4000, 0, 0);
    chk("R13 B to A block", {s_grant, s_fv, s_tb}, 0);
    chk("R13 no flags", {viol_flags_a, viol_flags_b}, 0);
  endtask

  task automatic t_master_viol();
    do_acc(0, 2'b10, 16'h8010, 0, 0);
    chk("R12 blocked fetch", {s_grant, s_fv}, 0);
    chk("R7 bus fault A", {s_fa, s_tb}, 2'b10);
    chk("R3 flag", viol_flags_a, 4'b0001);
    chk("R9 fetch addr", fetch_vaddr_a, 16'h8010);
    @(negedge clk);
    chk("R7 pulse ends", bus_fault_a, 0);
    do_acc(0, 2'b10, 16'h8020, 0, 0);
    chk("R9 first kept", fetch_vaddr_a, 16'h8010);
    do_acc(0, 2'b01, 16'h8030, 0, 0);
    chk("R12 blocked write", {s_grant, s_we}, 0);
    chk("R4 flag", viol_flags_a, 4'b0011);
    chk("R9 write addr", write_vaddr_a, 16'h8030);
    chk("R8 B untouched", {viol_flags_b, fetch_vaddr_b}, 0);
    do_acc(1, 2'b10, 16'h6040, 0, 0);
    chk("R7 trap B", {s_fa, s_tb}, 2'b01);
    chk("R8 B flag", viol_flags_b, 4'b0001);
    chk("R8 B addr", fetch_vaddr_b, 16'h6040);
    chk("R8 A untouched", viol_flags_a, 4'b0011);
  endtask

  task automatic t_nonmaster();
    blk_master[6] = 1'b0;
    do_acc(1, 2'b01, 16'hC008, 0, 0);
    chk("R5 nm write", {s_grant, s_tb}, 2'b01);
    chk("R5 nm write flag", viol_flags_b, 4'b1001);
    chk("R9 B write addr", write_vaddr_b, 16'hC008);
    do_acc(1, 2'b10, 16'hC00C, 0, 0);
    chk("R5 nm fetch flag", viol_flags_b, 4'b1101);
    chk("R9 B fetch kept", fetch_vaddr_b, 16'h6040);
  endtask

  task automatic t_clear();
    do_clr(4'b0001, 0);
    chk("R10 clear bit0", viol_flags_a, 4'b0010);
    do_acc(0, 2'b10, 16'h8050, 0, 0);
    chk("R9 recapture", fetch_vaddr_a, 16'h8050);
    do_clr(0, 4'b1000);
    chk("R10 clear B bit3", viol_flags_b, 4'b0101);
    do_acc(0, 2'b10, 16'h8060, 4'b0001, 0);
    chk("R11 flag stays", viol_flags_a, 4'b0011);
    chk("R11 new addr", fetch_vaddr_a, 16'h8060);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_cpu = 1'b0; req_kind = '0; req_addr = '0;
    blk_master = '0; blk_fetch_prot = '0; blk_wr_prot = '0;
    flag_clr_a = '0; flag_clr_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_allowed();
    t_reads();
    t_exempt();
    t_foreign();
    t_master_viol();
    t_nonmaster();
    t_clear();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule